// File: doc/BRIEF.md
# Programmable 3x3 Neighbourhood Filter

This block filters a stream of 8-bit monochrome pixels with a 3x3 kernel whose nine signed weights can be changed while the block runs. The same hardware can therefore act as a smoothing filter, a sharpening filter or an edge detector. The input takes one pixel per clock. A valid strobe qualifies each pixel, and start-of-frame and start-of-line flags mark its position. Cycles with the strobe low are blanking or stall cycles, and the block ignores them completely.

The block keeps two full image lines in on-chip storage. It assembles a window from the two stored lines and the arriving pixel. Each output pixel belongs to the window whose bottom-right corner is the pixel just accepted. The weighted sum of that window is shifted right by a programmable amount and clamped to 0..255. The output is zero whenever the window reaches above the first row or left of the first column of the frame. A narrow register write port loads the weights and the shift amount.

Top module: `nbhd_filter3x3`

## Requirements
- R1: After reset, out_valid and out_pix are 0, every weight is 0 and the shift is 0, so every output pixel of a first frame is 0.
- R2: A pixel accepted (in_valid high) in cycle n produces exactly one output with out_valid high in cycle n+3, carrying that pixel's in_sof and in_sol values on out_sof and out_sol. No output appears for any other cycle. Frames may follow each other with no idle cycle between them.
- R3: For a pixel at row r, column c, the output is clamp(S >>> k) with S = sum over i,j in 0..2 of w[3i+j] * p(r-2+i, c-2+j). Pixels are unsigned, weights are 8-bit two's complement, and k is the shift value.
- R4: A write with cfg_we high, cfg_addr 0..8 sets weight w[cfg_addr], where index 3i+j weights row offset i and column offset j (index 0 is the oldest row and leftmost column). Address 9 sets k from cfg_wdata[3:0]. Writes to addresses 10..15 change nothing.
- R5: Position tracking works as follows. A pixel with in_sof is row 0, column 0. A pixel with in_sol (and no in_sof) starts the next row at column 0. Any other pixel is one column to the right of the previous one. If r < 2 or c < 2, the output is 0 whatever the weights.
- R6: A negative shifted sum gives 0, and a shifted sum above 255 gives 255.
- R7: Idle cycles between accepted pixels leave the results unchanged, whatever in_pix, in_sof and in_sol carry during those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel qualifier |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | PIX_W | Input pixel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration address (0..8 weights, 9 shift) |
| cfg_wdata | input | COEF_W | Configuration write data |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | Delayed frame-start flag |
| out_sol | output | 1 | Delayed line-start flag |
| out_pix | output | PIX_W | Filtered, scaled and clamped pixel |

## Verification
The border rule and the clamp can land on the same output pixel. This happens when weights that would saturate every pixel are applied to an edge position. The bench provokes it with all weights at 127, no shift, and a bright flat frame. The rule is judged met when every interior result reads 255 and every pixel in the first two rows and columns reads 0. A second overlap, the last results of one frame still in flight while the next frame's start pixel enters, is provoked with back-to-back frames. There the flags and values must stay attached to their own pixels.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  localparam int KDIM   = 3;
  localparam int NTAPS  = KDIM * KDIM;
  localparam int LB_CNT = KDIM - 1;

  typedef enum logic [1:0] {
    CFG_NONE  = 2'd0,
    CFG_TAP   = 2'd1,
    CFG_SHIFT = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/nbf_coef_bank.sv
module nbf_coef_bank
  import nbf_pkg::*;
#(
  parameter int COEF_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int CFG_AW  = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [CFG_AW-1:0]                  addr,
  input  logic [COEF_W-1:0]                  wdata,
  output logic [NTAPS-1:0][COEF_W-1:0]       coef,
  output logic [SHIFT_W-1:0]                 shift
);
  cfg_sel_e                         sel;
  logic [NTAPS-1:0][COEF_W-1:0]     coef_d, coef_q;
  logic [SHIFT_W-1:0]               shift_d, shift_q;

  always_comb begin
    if (!we)                                sel = CFG_NONE;
    else if (addr < CFG_AW'(NTAPS))         sel = CFG_TAP;
    else if (addr == CFG_AW'(NTAPS))        sel = CFG_SHIFT;
    else                                    sel = CFG_NONE;
  end

  always_comb begin
    coef_d  = coef_q;
    shift_d = shift_q;
    for (int t = 0; t < NTAPS; t++) begin
      if (sel == CFG_TAP && addr == CFG_AW'(t)) coef_d[t] = wdata;
    end
    if (sel == CFG_SHIFT) shift_d = wdata[SHIFT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q  <= '0;
      shift_q <= '0;
    end else begin
      coef_q  <= coef_d;
      shift_q <= shift_d;
    end
  end

  assign coef  = coef_q;
  assign shift = shift_q;
endmodule

// File: rtl/nbf_window.sv
module nbf_window
  import nbf_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int PIX_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic                                   in_sof,
  input  logic                                   in_sol,
  input  logic [PIX_W-1:0]                       in_pix,
  output logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0]   win,
  output logic                                   win_valid,
  output logic                                   win_sof,
  output logic                                   win_sol,
  output logic                                   win_border
);
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int ROW_W = $clog2(KDIM);

  logic [COL_W-1:0] col_q, col_d, cur_col;
  logic [ROW_W-1:0] row_q, row_d, cur_row;
  logic             border;

  logic [LB_CNT-1:0][PIX_W-1:0]                 lb_rd, lb_wr;
  logic [KDIM-1:0][PIX_W-1:0]                   col_in;
  logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0]         win_d, win_q;
  logic valid_q, sof_q, sol_q, border_q;

  // position of the pixel on the input
  always_comb begin
    if (in_sof || in_sol)                      cur_col = '0;
    else if (col_q == COL_W'(IMG_W - 1))       cur_col = col_q;
    else                                       cur_col = col_q + 1'b1;

    if (in_sof)                                cur_row = '0;
    else if (in_sol && row_q != ROW_W'(KDIM - 1)) cur_row = row_q + 1'b1;
    else                                       cur_row = row_q;

    border = (cur_row < ROW_W'(KDIM - 1)) || (cur_col < COL_W'(KDIM - 1));
  end

  // line stores: line 0 holds the previous row, line g holds row r-1-g
  for (genvar g = 0; g < LB_CNT; g++) begin : g_line
    logic [PIX_W-1:0] mem [IMG_W];
    if (g == 0) begin : g_head
      assign lb_wr[g] = in_pix;
    end else begin : g_chain
      assign lb_wr[g] = lb_rd[g-1];
    end
    assign lb_rd[g] = mem[cur_col];
    always_ff @(posedge clk) begin
      if (in_valid) mem[cur_col] <= lb_wr[g];
    end
  end

  // new window column, top entry is the oldest row
  assign col_in[KDIM-1] = in_pix;
  for (genvar r = 0; r < KDIM - 1; r++) begin : g_colin
    assign col_in[r] = lb_rd[KDIM-2-r];
  end

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    win_d = win_q;
    if (in_valid) begin
      col_d = cur_col;
      row_d = cur_row;
      for (int r = 0; r < KDIM; r++) begin
        for (int c = 0; c < KDIM - 1; c++) win_d[r][c] = win_q[r][c+1];
        win_d[r][KDIM-1] = col_in[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      row_q    <= '0;
      win_q    <= '0;
      valid_q  <= 1'b0;
      sof_q    <= 1'b0;
      sol_q    <= 1'b0;
      border_q <= 1'b0;
    end else begin
      col_q    <= col_d;
      row_q    <= row_d;
      win_q    <= win_d;
      valid_q  <= in_valid;
      sof_q    <= in_valid & in_sof;
      sol_q    <= in_valid & in_sol;
      border_q <= in_valid & border;
    end
  end

  assign win        = win_q;
  assign win_valid  = valid_q;
  assign win_sof    = sof_q;
  assign win_sol    = sol_q;
  assign win_border = border_q;
endmodule

// File: rtl/nbf_mac.sv
module nbf_mac
  import nbf_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COEF_W  = 8,
  parameter int SHIFT_W = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0]   win,
  input  logic                                   win_valid,
  input  logic                                   win_sof,
  input  logic                                   win_sol,
  input  logic                                   win_border,
  input  logic [NTAPS-1:0][COEF_W-1:0]           coef,
  input  logic [SHIFT_W-1:0]                     shift,
  output logic                                   out_valid,
  output logic                                   out_sof,
  output logic                                   out_sol,
  output logic [PIX_W-1:0]                       out_pix
);
  localparam int PROD_W = PIX_W + COEF_W + 1;
  localparam int ACC_W  = PROD_W + $clog2(NTAPS);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((2 ** PIX_W) - 1);

  logic signed [PROD_W-1:0] prod_d [NTAPS];
  logic signed [PROD_W-1:0] prod_q [NTAPS];
  logic va_q, sofa_q, sola_q, bordera_q;

  logic signed [ACC_W-1:0] acc, scaled;
  logic [PIX_W-1:0]        clamped, pix_d;
  logic                    vo_q, sofo_q, solo_q;
  logic [PIX_W-1:0]        pixo_q;

  // stage A: one product per tap
  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    logic signed [PROD_W-1:0] px_ext, cf_ext;
    assign px_ext    = {{(COEF_W + 1){1'b0}}, win[t / KDIM][t % KDIM]};
    assign cf_ext    = {{(PIX_W + 1){coef[t][COEF_W-1]}}, coef[t]};
    assign prod_d[t] = px_ext * cf_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTAPS; t++) prod_q[t] <= '0;
      va_q      <= 1'b0;
      sofa_q    <= 1'b0;
      sola_q    <= 1'b0;
      bordera_q <= 1'b0;
    end else begin
      for (int t = 0; t < NTAPS; t++) prod_q[t] <= prod_d[t];
      va_q      <= win_valid;
      sofa_q    <= win_sof;
      sola_q    <= win_sol;
      bordera_q <= win_border;
    end
  end

  // stage B: sum, scale, clamp, border forcing
  always_comb begin
    acc = '0;
    for (int t = 0; t < NTAPS; t++) begin
      acc = acc + $signed({{(ACC_W - PROD_W){prod_q[t][PROD_W-1]}}, prod_q[t]});
    end
    scaled = acc >>> shift;
    if (scaled < 0)             clamped = '0;
    else if (scaled > PIX_MAX)  clamped = '1;
    else                        clamped = scaled[PIX_W-1:0];
    pix_d = bordera_q ? '0 : clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vo_q   <= 1'b0;
      sofo_q <= 1'b0;
      solo_q <= 1'b0;
      pixo_q <= '0;
    end else begin
      vo_q   <= va_q;
      sofo_q <= sofa_q;
      solo_q <= sola_q;
      if (va_q) pixo_q <= pix_d;
    end
  end

  assign out_valid = vo_q;
  assign out_sof   = sofo_q;
  assign out_sol   = solo_q;
  assign out_pix   = pixo_q;
endmodule

// File: rtl/nbhd_filter3x3.sv
module nbhd_filter3x3
  import nbf_pkg::*;
#(
  parameter int IMG_W   = 640,
  parameter int PIX_W   = 8,
  parameter int COEF_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int CFG_AW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_sol,
  input  logic [PIX_W-1:0]   in_pix,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [COEF_W-1:0]  cfg_wdata,
  output logic               out_valid,
  output logic               out_sof,
  output logic               out_sol,
  output logic [PIX_W-1:0]   out_pix
);
  logic rst_meta_q, rst_sync_n;

  logic [NTAPS-1:0][COEF_W-1:0]         coef_vec;
  logic [SHIFT_W-1:0]                   shift_q;
  logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0] win;
  logic win_valid, win_sof, win_sol, win_border;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  nbf_coef_bank #(
    .COEF_W (COEF_W),
    .SHIFT_W(SHIFT_W),
    .CFG_AW (CFG_AW)
  ) u_coef (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .coef (coef_vec),
    .shift(shift_q)
  );

  nbf_window #(
    .IMG_W(IMG_W),
    .PIX_W(PIX_W)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_sol    (in_sol),
    .in_pix    (in_pix),
    .win       (win),
    .win_valid (win_valid),
    .win_sof   (win_sof),
    .win_sol   (win_sol),
    .win_border(win_border)
  );

  nbf_mac #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W),
    .SHIFT_W(SHIFT_W)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .win       (win),
    .win_valid (win_valid),
    .win_sof   (win_sof),
    .win_sol   (win_sol),
    .win_border(win_border),
    .coef      (coef_vec),
    .shift     (shift_q),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_sol   (out_sol),
    .out_pix   (out_pix)
  );
endmodule

// File: rtl/nbf_checker.sv
module nbf_checker
  import nbf_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COEF_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int CFG_AW  = 4
) (
  input logic                           clk,
  input logic                           rst_sync_n,
  input logic                           in_valid,
  input logic                           in_sof,
  input logic                           in_sol,
  input logic                           cfg_we,
  input logic [CFG_AW-1:0]              cfg_addr,
  input logic [COEF_W-1:0]              cfg_wdata,
  input logic [NTAPS-1:0][COEF_W-1:0]   coef_vec,
  input logic [SHIFT_W-1:0]             shift_q,
  input logic                           out_valid,
  input logic                           out_sof,
  input logic                           out_sol,
  input logic [PIX_W-1:0]               out_pix
);
  // edges seen since reset release, saturating at the pipeline depth
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)            since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (since_rst == 2'd3 && $past(in_valid, 3)) |-> out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (since_rst == 2'd3 && out_valid) |-> $past(in_valid, 3));

  assert_flags_follow_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (since_rst == 2'd3 && out_valid) |->
      (out_sof == $past(in_sof, 3) && out_sol == $past(in_sol, 3)));

  assert_frame_start_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (since_rst == 2'd3 && out_valid && out_sof) |-> (out_pix == '0));

  assert_reserved_ignored_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_addr > CFG_AW'(NTAPS)) |=> ($stable(coef_vec) && $stable(shift_q)));

  assert_tap_write_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_addr < CFG_AW'(NTAPS)) |=> (coef_vec[$past(cfg_addr)] == $past(cfg_wdata)));

  assert_shift_write_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_addr == CFG_AW'(NTAPS)) |=> (shift_q == $past(cfg_wdata[SHIFT_W-1:0])));
endmodule

bind nbhd_filter3x3 nbf_checker #(
  .PIX_W  (PIX_W),
  .COEF_W (COEF_W),
  .SHIFT_W(SHIFT_W),
  .CFG_AW (CFG_AW)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_sol    (in_sol),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .coef_vec  (coef_vec),
  .shift_q   (shift_q),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_sol   (out_sol),
  .out_pix   (out_pix)
);

// File: tb/nbhd_filter3x3_test.sv
`timescale 1ns/1ps
module nbhd_filter3x3_test;
  localparam int W    = 10;
  localparam int MAXH = 8;

  logic       clk, rst_n;
  logic       in_valid, in_sof, in_sol;
  logic [7:0] in_pix;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       out_valid, out_sof, out_sol;
  logic [7:0] out_pix;

  typedef struct {
    int    pix;
    bit    sof;
    bit    sol;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   compared   = 0;
  int   mismatched = 0;
  int   cb[9];
  int   sh;
  int   frm[MAXH][W];

  nbhd_filter3x3 #(.IMG_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_pix(in_pix),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol), .out_pix(out_pix)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per produced output
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sbq.size() == 0) begin
        check("R2", "output with nothing pending", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(e.tag, "pixel", int'(out_pix), e.pix);
        check("R2", "sof flag", int'(out_sof), int'(e.sof));
        check("R2", "sol flag", int'(out_sol), int'(e.sol));
      end
    end
  end

  function automatic int expect_px(int r, int c);
    int s;
    if (r < 2 || c < 2) return 0;
    s = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        s += cb[i*3+j] * frm[r-2+i][c-2+j];
    s = s >>> sh;
    if (s < 0)   return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  function automatic int gen_pix(int pat, int r, int c);
    case (pat)
      0: return (r * 17 + c * 11) & 255;
      1: return int'($urandom % 256);
      2: return 250;
      3: return c * 25;
      default: return 255 - c * 25;
    endcase
  endfunction

  task automatic wr_cfg(int a, int d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 4'(a);
    cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
    if (a < 9)       cb[a] = int'($signed(8'(d)));
    else if (a == 9) sh = d & 15;
  endtask

  task automatic set_kernel(int k0, int k1, int k2, int k3, int k4,
                            int k5, int k6, int k7, int k8, int s);
    wr_cfg(0, k0); wr_cfg(1, k1); wr_cfg(2, k2);
    wr_cfg(3, k3); wr_cfg(4, k4); wr_cfg(5, k5);
    wr_cfg(6, k6); wr_cfg(7, k7); wr_cfg(8, k8);
    wr_cfg(9, s);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b1;          // garbage during blanking
      in_sol   = 1'b1;
      in_pix   = 8'($urandom);
    end
  endtask

  // leaves in_valid high on the last pixel; caller idles afterwards
  task automatic send_frame(int h, int pat, bit gaps, string tag);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < W; c++)
        frm[r][c] = gen_pix(pat, r, c);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < W; c++) begin
        exp_t e;
        if (gaps) idle(int'($urandom % 3));
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_sol   = (r > 0 && c == 0);
        in_pix   = 8'(frm[r][c]);
        e.pix = expect_px(r, c);
        e.sof = (r == 0 && c == 0);
        e.sol = (r > 0 && c == 0);
        e.tag = tag;
        sbq.push_back(e);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) cb[i] = 0;
    sh        = 0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sof    = 1'b0;
    in_sol    = 1'b0;
    in_pix    = '0;
    cfg_we    = 1'b0;
    cfg_addr  = '0;
    cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R1", "out_valid after reset", int'(out_valid), 0);
      check("R1", "out_pix after reset", int'(out_pix), 0);
    end

    // R1: reset weights give an all-zero frame
    send_frame(4, 1, 1'b0, "R1");
    idle(6);

    // R3: identity on centre tap, then box sum with scaling
    set_kernel(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    send_frame(5, 0, 1'b0, "R3");
    idle(6);
    set_kernel(1, 1, 1, 1, 1, 1, 1, 1, 1, 3);
    send_frame(5, 1, 1'b0, "R3");
    idle(6);

    // R6: horizontal gradient kernel, both clamp directions
    set_kernel(-1, 0, 1, -2, 0, 2, -1, 0, 1, 0);
    send_frame(4, 3, 1'b0, "R6");
    idle(6);
    send_frame(4, 4, 1'b0, "R6");
    idle(6);
    send_frame(5, 1, 1'b0, "R6");
    idle(6);

    // R7: idle cycles with garbage between pixels
    set_kernel(1, 2, 1, 2, 4, 2, 1, 2, 1, 4);
    send_frame(5, 1, 1'b1, "R7");
    idle(6);

    // R4: tap order, shift field, ignored addresses
    set_kernel(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    wr_cfg(12, 8'h55);
    wr_cfg(15, 8'h7F);
    wr_cfg(10, 8'h33);
    send_frame(4, 0, 1'b0, "R4");
    idle(6);
    wr_cfg(0, 0);
    wr_cfg(8, 2);
    wr_cfg(9, 8'h21);          // only the low four bits count
    send_frame(4, 1, 1'b0, "R4");
    idle(6);

    // R5: border zero coinciding with saturation
    set_kernel(127, 127, 127, 127, 127, 127, 127, 127, 127, 0);
    send_frame(4, 2, 1'b0, "R5");
    idle(6);

    // R2: back-to-back frames with no gap
    set_kernel(0, 1, 0, 1, -4, 1, 0, 1, 0, 0);
    send_frame(3, 0, 1'b0, "R2");
    send_frame(4, 1, 1'b0, "R2");
    idle(8);

    check("R2", "pending outputs at end", sbq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule